// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

This block is an 8-bit timer/counter with one compare channel and the logic that drives a compare output pin. The counter advances only on prescaled ticks, one tick every `PRESCALE` clocks while the run bit is set. Three counting modes are offered: free-running, clear-on-compare (CTC) and fast PWM. A 2-bit output-action field selects how the pin register reacts to a compare match and to the counter reaching TOP. The right action depends on both this field and the counting mode.

Software configures the unit through a small register port: a write strobe with address and data, and a registered read port. The block drives the pin value, an override enable that tells the I/O port the pin has been taken over, and a sticky compare flag. Software clears the flag by writing 1 to it.

Top module: `timer_cmp_unit`

## Requirements
- R1: After a synchronous reset the counter, the pin register, the compare flag, the override enable and every configuration register read as 0.
- R2: While the run bit (bit 1 at address 1) is 1, the counter changes only once every PRESCALE clocks. The first change comes PRESCALE clocks after the run bit is written to 1. While the run bit is 0 the counter holds its value.
- R3: In free-running mode (mode bits 1:0 = 00, or the reserved 01), the counter counts up to 0xFF and wraps to 0 on the next tick.
- R4: In CTC mode (mode bits 1:0 = 10), TOP is the compare value. The tick that finds the counter at the compare value loads 0 and raises the compare flag.
- R5: A compare match is a tick taken while the counter equals the compare value, and it sets the flag. The flag stays set until a write of 1 to bit 0 at address 3. If a match and a clear land in the same cycle, the set wins.
- R6: In the non-PWM modes the action field works as follows on a compare match: 01 toggles the pin, 10 clears it and 11 sets it.
- R7: In fast PWM mode (mode bits 1:0 = 11), TOP is 0xFF when the extended mode bit (bit 0 at address 1) is 0. TOP is the compare value when that bit is 1. A tick at TOP loads 0.
- R8: In fast PWM mode, action 10 clears the pin on a match and sets it at TOP. Action 11 sets the pin on a match and clears it at TOP.
- R9: In fast PWM mode with action 01, the pin is released when the extended mode bit is 0: the override is off and the pin register holds. When that bit is 1, the pin toggles on a match.
- R10: In fast PWM mode, when the compare value equals TOP and bit 1 of the action field is 1, the match action is suppressed and only the TOP action applies. The flag is still set.
- R11: The override enable is 1 whenever the action field is non-zero, except in the released case of R9.
- R12: Register map. Address 0 holds the action field at 7:6, a second-channel field at 5:4 (stored and read back only), bits 3:2 that always read 0, and mode bits 1:0. Address 1 holds the extended mode bit at 0 and the run bit at 1. Address 2 holds the compare value. Address 3 holds the flag at bit 0. Reads return data one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data |
| cnt_o | output | 8 | Current counter value |
| wave_o | output | 1 | Compare output pin value |
| ovr_en_o | output | 1 | Pin override enable toward the I/O port |
| cmp_flag_o | output | 1 | Sticky compare-match flag |

## Verification
The counter, the pin register and the flag all change on the clock edge that consumes a tick. The first tick is consumed exactly `n*PRESCALE` edges after the edge that writes the run bit. The bench therefore counts `n*PRESCALE` rising edges from that write and samples 2 ns later, well away from the next edge. Reads are due one edge after the address is driven, and each read is sampled just after that edge. The override enable settles one edge after a configuration write, and the bench looks at it only after many cycles have passed.

// File: rtl/timer_cmp_pkg.sv
package timer_cmp_pkg;

  typedef enum logic [1:0] {
    WM_FREE = 2'd0,
    WM_CTC  = 2'd1,
    WM_PWM  = 2'd2
  } wave_mode_e;

  typedef enum logic [1:0] {
    ACT_OFF    = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } out_act_e;

  function automatic wave_mode_e decode_mode(input logic [1:0] sel);
    case (sel)
      2'b10:   return WM_CTC;
      2'b11:   return WM_PWM;
      default: return WM_FREE;
    endcase
  endfunction

endpackage

// File: rtl/timer_prescale.sv
module timer_prescale #(
  parameter int PRESCALE = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  assign tick = run && (pre_q == LAST);

  generate
    if (PRESCALE > 1) begin : g_spacing
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R2
    end
  endgenerate

endmodule

// File: rtl/timer_count.sv
module timer_count
  import timer_cmp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  wave_mode_e       mode,
  input  logic             ext_top,
  input  logic [CNT_W-1:0] ocr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             top_ev,
  output logic             cmp_ev
);
  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  logic [CNT_W-1:0] top_val;

  always_comb begin
    if (mode == WM_CTC || (mode == WM_PWM && ext_top)) top_val = ocr;
    else top_val = MAX_VAL;
  end

  assign top_ev = tick && (cnt_q == top_val);
  assign cmp_ev = tick && (cnt_q == ocr);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (tick) begin
      if (cnt_q == top_val) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q)); // R2
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (mode == WM_FREE && tick && cnt_q == MAX_VAL) |=> cnt_q == '0); // R3
  AST_CTC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (mode == WM_CTC && tick && cnt_q == ocr) |=> cnt_q == '0); // R4
  AST_PWM_FULL_WRAP: assert property (@(posedge clk) disable iff (rst)
    (mode == WM_PWM && !ext_top && tick && cnt_q == MAX_VAL) |=> cnt_q == '0); // R7

endmodule

// File: rtl/timer_wave.sv
module timer_wave
  import timer_cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  wave_mode_e mode,
  input  logic       ext_top,
  input  logic [1:0] act,
  input  logic       top_ev,
  input  logic       cmp_ev,
  output logic       wave_q,
  output logic       ovr_q
);
  logic wave_d;
  logic released;

  assign released = (mode == WM_PWM) && (act == ACT_TOGGLE) && !ext_top;

  always_comb begin
    wave_d = wave_q;
    if (mode == WM_PWM) begin
      case (act)
        ACT_TOGGLE: if (ext_top && cmp_ev) wave_d = ~wave_q;
        ACT_CLEAR: begin
          if (top_ev) wave_d = 1'b1;
          else if (cmp_ev) wave_d = 1'b0;
        end
        ACT_SET: begin
          if (top_ev) wave_d = 1'b0;
          else if (cmp_ev) wave_d = 1'b1;
        end
        default: wave_d = wave_q;
      endcase
    end else if (cmp_ev) begin
      case (act)
        ACT_TOGGLE: wave_d = ~wave_q;
        ACT_CLEAR:  wave_d = 1'b0;
        ACT_SET:    wave_d = 1'b1;
        default:    wave_d = wave_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      wave_q <= wave_d;
      ovr_q  <= (act != ACT_OFF) && !released;
    end
  end

  AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(wave_q)); // R6
  AST_RELEASED_HOLD: assert property (@(posedge clk) disable iff (rst)
    released |=> $stable(wave_q)); // R9
  AST_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
    (mode == WM_PWM && act[1] && top_ev && cmp_ev) |=> wave_q == !$past(act[0])); // R10

endmodule

// File: rtl/timer_cmp_unit.sv
module timer_cmp_unit
  import timer_cmp_pkg::*;
#(
  parameter int PRESCALE = 8,
  parameter int CNT_W    = 8,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wave_o,
  output logic              ovr_en_o,
  output logic              cmp_flag_o
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_EXT  = 2'd1;
  localparam logic [1:0] A_CMP  = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  logic [1:0]       act_q;
  logic [1:0]       actb_q;
  logic [1:0]       sel_q;
  logic             ext_q;
  logic             run_q;
  logic [CNT_W-1:0] ocr_q;
  logic             flag_q;
  logic             flag_clr;
  logic             tick;
  logic             top_ev;
  logic             cmp_ev;
  wave_mode_e       mode;

  assign mode     = decode_mode(sel_q);
  assign flag_clr = wr_en && (wr_addr == A_FLAG) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      actb_q <= '0;
      sel_q  <= '0;
      ext_q  <= 1'b0;
      run_q  <= 1'b0;
      ocr_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          act_q  <= wr_data[7:6];
          actb_q <= wr_data[5:4];
          sel_q  <= wr_data[1:0];
        end
        A_EXT: begin
          ext_q <= wr_data[0];
          run_q <= wr_data[1];
        end
        A_CMP:   ocr_q <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else flag_q <= cmp_ev | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        A_CTRL:  rd_data <= {act_q, actb_q, 2'b00, sel_q};
        A_EXT:   rd_data <= {{(DATA_W-2){1'b0}}, run_q, ext_q};
        A_CMP:   rd_data <= DATA_W'(ocr_q);
        default: rd_data <= {{(DATA_W-1){1'b0}}, flag_q};
      endcase
    end
  end

  timer_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .run(run_q), .tick(tick)
  );

  timer_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .ext_top(ext_q),
    .ocr(ocr_q), .cnt_q(cnt_o), .top_ev(top_ev), .cmp_ev(cmp_ev)
  );

  timer_wave u_wave (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .ext_top(ext_q),
    .act(act_q), .top_ev(top_ev), .cmp_ev(cmp_ev),
    .wave_q(wave_o), .ovr_q(ovr_en_o)
  );

  assign cmp_flag_o = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    cmp_ev |=> cmp_flag_o); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag_o && !flag_clr) |=> cmp_flag_o); // R5
  AST_RO_BITS: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_CTRL) |=> rd_data[3:2] == 2'b00); // R12

endmodule

// File: tb/timer_cmp_unit_tb_top.sv
`timescale 1ns/1ps
module timer_cmp_unit_tb_top;
  localparam int PRE = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [7:0] cnt_o;
  logic       wave_o, ovr_en_o, cmp_flag_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  timer_cmp_unit #(.PRESCALE(PRE)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_o(cnt_o), .wave_o(wave_o),
    .ovr_en_o(ovr_en_o), .cmp_flag_o(cmp_flag_o)
  );

  // {req[3:0], act[1:0], sel[1:0], ext, ocr[7:0], ticks[15:0], cnt[7:0], pin, flag, ovr}
  localparam int NV = 18;
  localparam logic [43:0] VEC [NV] = '{
    {4'd6,  2'b01, 2'b00, 1'b0, 8'd3, 16'd3,   8'd3, 1'b0, 1'b0, 1'b1}, // R6 before match
    {4'd6,  2'b01, 2'b00, 1'b0, 8'd3, 16'd4,   8'd4, 1'b1, 1'b1, 1'b1}, // R6 toggle
    {4'd6,  2'b11, 2'b00, 1'b0, 8'd5, 16'd6,   8'd6, 1'b1, 1'b1, 1'b1}, // R6 set
    {4'd6,  2'b10, 2'b00, 1'b0, 8'd5, 16'd6,   8'd6, 1'b0, 1'b1, 1'b1}, // R6 clear
    {4'd3,  2'b01, 2'b00, 1'b0, 8'd2, 16'd259, 8'd3, 1'b0, 1'b1, 1'b1}, // R3 wrap, two toggles
    {4'd11, 2'b00, 2'b00, 1'b0, 8'd3, 16'd4,   8'd4, 1'b0, 1'b1, 1'b0}, // R11 no override
    {4'd4,  2'b01, 2'b10, 1'b0, 8'd4, 16'd4,   8'd4, 1'b0, 1'b0, 1'b1}, // R4 at TOP
    {4'd4,  2'b01, 2'b10, 1'b0, 8'd4, 16'd5,   8'd0, 1'b1, 1'b1, 1'b1}, // R4 clear to 0
    {4'd4,  2'b01, 2'b10, 1'b0, 8'd4, 16'd10,  8'd0, 1'b0, 1'b1, 1'b1}, // R4 two periods
    {4'd7,  2'b10, 2'b11, 1'b0, 8'd2, 16'd256, 8'd0, 1'b1, 1'b1, 1'b1}, // R7 TOP 0xFF set
    {4'd8,  2'b10, 2'b11, 1'b0, 8'd2, 16'd259, 8'd3, 1'b0, 1'b1, 1'b1}, // R8 clear on match
    {4'd8,  2'b11, 2'b11, 1'b0, 8'd2, 16'd3,   8'd3, 1'b1, 1'b1, 1'b1}, // R8 set on match
    {4'd8,  2'b11, 2'b11, 1'b0, 8'd2, 16'd256, 8'd0, 1'b0, 1'b1, 1'b1}, // R8 clear at TOP
    {4'd9,  2'b01, 2'b11, 1'b1, 8'd3, 16'd4,   8'd0, 1'b1, 1'b1, 1'b1}, // R9 toggle
    {4'd9,  2'b01, 2'b11, 1'b1, 8'd3, 16'd8,   8'd0, 1'b0, 1'b1, 1'b1}, // R9 toggle twice
    {4'd9,  2'b01, 2'b11, 1'b0, 8'd3, 16'd4,   8'd4, 1'b0, 1'b1, 1'b0}, // R9 released
    {4'd10, 2'b10, 2'b11, 1'b1, 8'd5, 16'd6,   8'd0, 1'b1, 1'b1, 1'b1}, // R10 only set at TOP
    {4'd10, 2'b11, 2'b11, 1'b1, 8'd5, 16'd6,   8'd0, 1'b0, 1'b1, 1'b1}  // R10 only clear at TOP
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    #1 d = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * PRE) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [7:0] held;
    do_reset();
    #2;
    // R1 reset state
    check("R1 cnt", cnt_o, 0);
    check("R1 pin", wave_o, 0);
    check("R1 flag", cmp_flag_o, 0);
    check("R1 ovr", ovr_en_o, 0);
    rd(2'd0, d); check("R1 ctrl", d, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[43:40], i);
      do_reset();
      wr(2'd0, {v[39:38], 2'b00, 2'b00, v[37:36]});
      wr(2'd2, v[34:27]);
      wr(2'd1, {6'd0, 1'b0, v[35]});
      wr(2'd1, {6'd0, 1'b1, v[35]});
      wait_ticks(int'(v[26:11]));
      check({tag, " cnt"}, cnt_o, int'(v[10:3]));
      check({tag, " pin"}, wave_o, int'(v[2]));
      check({tag, " flag"}, cmp_flag_o, int'(v[1]));
      check({tag, " ovr"}, ovr_en_o, int'(v[0]));
    end

    // R12 register readback and read-only bits
    do_reset();
    wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R12 ctrl ro bits", d, 8'hF3);
    wr(2'd2, 8'h5A);
    rd(2'd2, d); check("R12 compare reg", d, 8'h5A);
    wr(2'd1, 8'h01);
    rd(2'd1, d); check("R12 ext reg", d, 8'h01);

    // R2 counter holds between ticks and while stopped; R5 flag clear
    do_reset();
    wr(2'd0, 8'h40);
    wr(2'd2, 8'd1);
    wr(2'd1, 8'h02);
    wait_ticks(3);
    check("R2 cnt after 3 ticks", cnt_o, 3);
    repeat (PRE - 1) @(posedge clk);
    #2 check("R2 hold between ticks", cnt_o, 3);
    check("R5 flag sticky", cmp_flag_o, 1);
    rd(2'd3, d); check("R12 flag readback", d, 8'h01);
    wr(2'd1, 8'h00);
    held = cnt_o;
    repeat (40) @(posedge clk);
    #2 check("R2 hold when stopped", cnt_o, int'(held));
    wr(2'd3, 8'h00);
    #1 check("R5 write 0 keeps flag", cmp_flag_o, 1);
    wr(2'd3, 8'h01);
    #1 check("R5 write 1 clears flag", cmp_flag_o, 0);

    // R1 reset after activity
    do_reset();
    #2;
    check("R1 cnt after run", cnt_o, 0);
    check("R1 pin after run", wave_o, 0);
    check("R1 ovr after run", ovr_en_o, 0);
    rd(2'd2, d); check("R1 compare reg", d, 0);

    finish_run();
  end

endmodule